// File: doc/BRIEF.md
# Shift-Register Return Address Stack

A fixed-depth return address store for a small processor core. Calls and interrupt entries push the program-counter return address, and returns pop it. The block has no pointer. Every push or pop physically moves the contents of all levels by one place. Level 0 is always the top of the stack.

The core reads the top level through a combinational output, so the returning address is available in the same cycle that the pop strobe is asserted. The stack raises no error on overflow or underflow, and both cases have defined data behaviour:
- Too many pushes: the bottom entry is shifted out and lost.
- A pop: the bottom level keeps its value, so repeated underflow returns the deepest address again.

A push and a pop in the same cycle replace the top entry only.

Top module: `rastk_stack`

## Requirements
- R1: While rst_ni is low, all levels are cleared to zero. After reset, top_o reads 0, and pops on the untouched stack keep returning 0.
- R2: top_o always equals the current contents of level 0. During a pop cycle, it shows the address being returned before the clock edge.
- R3: A push alone (push_i=1, pop_i=0) loads push_addr_i into level 0 at the rising clock edge. It is visible on top_o one cycle after the strobe.
- R4: On a push alone, level 0 moves to level 1 and level 1 moves to level 2 in the same edge.
- R5: With DEPTH=3, the old bottom entry is discarded on a push. After four pushes A1..A4, the following pops return A4, then A3, then A2.
- R6: A pop alone (pop_i=1, push_i=0) moves each level up by one place, and the bottom level keeps its value. Four pushes A1..A4 followed by four pops return A4, A3, A2, A2.
- R7: A push and a pop asserted together replace level 0 with push_addr_i and leave all deeper levels unchanged.
- R8: With neither strobe asserted, no level changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low; clears all levels |
| push_i | input | 1 | Push strobe (call or interrupt entry) |
| pop_i | input | 1 | Pop strobe (return) |
| push_addr_i | input | AW (9) | Return address to push |
| top_o | output | AW (9) | Contents of level 0, the returning address |

## Verification
top_o reflects level 0 with no delay, so the bench reads it a short time after driving the strobes in the falling half of the clock. That reading checks the address presented during a pop. Every shift, load or replace takes effect at the following rising edge, so the next value is checked one cycle after the strobe, again in the falling half. The bench keeps a three-entry model that advances once per rising edge. Each reading is compared with that model, so no expected value depends on sampling at the edge itself.

// File: rtl/rastk_pkg.sv
package rastk_pkg;

  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } stk_op_e;

endpackage

// File: rtl/rastk_op_dec.sv
module rastk_op_dec
  import rastk_pkg::*;
(
  input  logic    push_i,
  input  logic    pop_i,
  output stk_op_e op_o
);

  always_comb begin
    unique case ({push_i, pop_i})
      2'b10:   op_o = OP_PUSH;
      2'b01:   op_o = OP_POP;
      2'b11:   op_o = OP_SWAP;
      default: op_o = OP_HOLD;
    endcase
  end

endmodule

// File: rtl/rastk_level.sv
module rastk_level
  import rastk_pkg::*;
#(
  parameter int unsigned AW     = 9,
  parameter bit          IS_TOP = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  stk_op_e       op_i,
  input  logic [AW-1:0] from_up_i,
  input  logic [AW-1:0] from_dn_i,
  output logic [AW-1:0] q_o
);

  logic [AW-1:0] d;
  logic [AW-1:0] swap_d;

  // replace only touches the top level
  if (IS_TOP) begin : g_top
    assign swap_d = from_up_i;
  end else begin : g_deep
    assign swap_d = q_o;
  end

  always_comb begin
    unique case (op_i)
      OP_PUSH: d = from_up_i;
      OP_POP:  d = from_dn_i;
      OP_SWAP: d = swap_d;
      default: d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d;
  end

endmodule

// File: rtl/rastk_stack.sv
module rastk_stack
  import rastk_pkg::*;
#(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned AW    = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_addr_i,
  output logic [AW-1:0] top_o
);

  localparam int unsigned LAST = DEPTH - 1;

  stk_op_e       op;
  logic [AW-1:0] lvl_q [DEPTH];

  rastk_op_dec u_dec (
    .push_i (push_i),
    .pop_i  (pop_i),
    .op_o   (op)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    logic [AW-1:0] up_d;
    logic [AW-1:0] dn_d;

    if (i == 0) begin : g_up_new
      assign up_d = push_addr_i;
    end else begin : g_up_lvl
      assign up_d = lvl_q[i-1];
    end

    // bottom level refills from itself on pop
    if (i == LAST) begin : g_dn_self
      assign dn_d = lvl_q[i];
    end else begin : g_dn_lvl
      assign dn_d = lvl_q[i+1];
    end

    rastk_level #(
      .AW     (AW),
      .IS_TOP (i == 0)
    ) u_level (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .op_i      (op),
      .from_up_i (up_d),
      .from_dn_i (dn_d),
      .q_o       (lvl_q[i])
    );
  end

  assign top_o = lvl_q[0];

endmodule

// File: rtl/rastk_stack_chk.sv
module rastk_stack_chk #(
  parameter int unsigned DEPTH = 3,
  parameter int unsigned AW    = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          push_i,
  input logic          pop_i,
  input logic [AW-1:0] push_addr_i,
  input logic [AW-1:0] top_o,
  input logic [AW-1:0] lvl_q [DEPTH]
);

  localparam int unsigned LAST = DEPTH - 1;

  logic all_zero;
  always_comb begin
    all_zero = 1'b1;
    for (int k = 0; k < DEPTH; k++) if (lvl_q[k] != '0) all_zero = 1'b0;
  end

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> all_zero);

  assert_push_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> top_o == $past(push_addr_i));

  assert_swap_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> top_o == $past(push_addr_i));

  assert_pop_bottom_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> $stable(lvl_q[LAST]));

  for (genvar i = 1; i < DEPTH; i++) begin : g_deep
    assert_push_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && !pop_i) |=> lvl_q[i] == $past(lvl_q[i-1]));

    assert_pop_shift_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pop_i && !push_i) |=> lvl_q[i-1] == $past(lvl_q[i]));

    assert_swap_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && pop_i) |=> $stable(lvl_q[i]));
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_all
    assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!push_i && !pop_i) |=> $stable(lvl_q[i]));
  end

endmodule

bind rastk_stack rastk_stack_chk #(
  .DEPTH (DEPTH),
  .AW    (AW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .push_addr_i (push_addr_i),
  .top_o       (top_o),
  .lvl_q       (lvl_q)
);

// File: tb/rastk_stack_tb.sv
`timescale 1ns/1ps
module rastk_stack_tb_top;

  localparam int unsigned DEPTH = 3;
  localparam int unsigned AW    = 9;
  localparam int unsigned NRAND = 3000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          push_i = 1'b0;
  logic          pop_i = 1'b0;
  logic [AW-1:0] push_addr_i = '0;
  logic [AW-1:0] top_o;

  logic [AW-1:0] mdl [DEPTH];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  rastk_stack #(.DEPTH(DEPTH), .AW(AW)) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .push_addr_i (push_addr_i),
    .top_o       (top_o)
  );

  function automatic logic [AW-1:0] mdl_next(input int idx, input bit p, input bit q,
                                             input logic [AW-1:0] a);
    if (p && !q) return (idx == 0) ? a : mdl[idx-1];
    if (q && !p) return (idx == DEPTH-1) ? mdl[idx] : mdl[idx+1];
    if (p && q)  return (idx == 0) ? a : mdl[idx];
    return mdl[idx];
  endfunction

  task automatic check(input string req, input logic [AW-1:0] exp);
    checks++;
    if (top_o !== exp) begin
      errors++;
      $display("FAIL %s top_o=%0h expected=%0h", req, top_o, exp);
    end
  endtask

  // drive in low phase, check combinational top, then advance one edge
  task automatic step(input bit p, input bit q, input logic [AW-1:0] a, input string req);
    logic [AW-1:0] nx [DEPTH];
    push_i = p; pop_i = q; push_addr_i = a;
    #0.5;
    check("R2", mdl[0]);
    for (int k = 0; k < DEPTH; k++) nx[k] = mdl_next(k, p, q, a);
    @(posedge clk_i);
    for (int k = 0; k < DEPTH; k++) mdl[k] = nx[k];
    @(negedge clk_i);
    push_i = 1'b0; pop_i = 1'b0;
    #0.5;
    check(req, mdl[0]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < DEPTH; k++) mdl[k] = '0;
    // R1: reset state
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R1", '0);
    rst_ni = 1'b1;
    step(1'b0, 1'b1, '0, "R1");
    step(1'b0, 1'b1, '0, "R1");
    step(1'b0, 1'b0, '0, "R8");

    // R5/R6: four pushes then four pops -> A4 A3 A2 A2
    step(1'b1, 1'b0, 9'h101, "R3");
    step(1'b1, 1'b0, 9'h0a2, "R4");
    step(1'b1, 1'b0, 9'h1c3, "R4");
    step(1'b1, 1'b0, 9'h054, "R5");
    check("R5", 9'h054);
    step(1'b0, 1'b1, '0, "R5");
    check("R5", 9'h1c3);
    step(1'b0, 1'b1, '0, "R5");
    check("R5", 9'h0a2);
    step(1'b0, 1'b1, '0, "R6");
    check("R6", 9'h0a2);
    step(1'b0, 1'b1, '0, "R6");
    check("R6", 9'h0a2);

    // R7: replace keeps deeper levels
    step(1'b1, 1'b0, 9'h011, "R3");
    step(1'b1, 1'b0, 9'h022, "R3");
    step(1'b1, 1'b1, 9'h1ff, "R7");
    check("R7", 9'h1ff);
    step(1'b0, 1'b1, '0, "R7");
    check("R7", 9'h011);
    step(1'b0, 1'b0, 9'h155, "R8");
    check("R8", 9'h011);

    for (int n = 0; n < NRAND; n++) begin
      bit p, q;
      logic [AW-1:0] a;
      p = $urandom_range(0, 1);
      q = $urandom_range(0, 1);
      a = AW'($urandom);
      step(p, q, a, (p && q) ? "R7" : p ? "R3" : q ? "R6" : "R8");
    end

    // R1: asynchronous reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #0.5;
    check("R1", '0);
    for (int k = 0; k < DEPTH; k++) mdl[k] = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(1'b0, 1'b1, '0, "R1");
    finish_run();
  end

endmodule